// File: doc/BRIEF.md
# Erase-Block Write Protection Controller

This block keeps the write-protection state of every erase block in a flash array. Each block is open (programmable), locked, or pinned. A pinned block is locked, and software cannot open it while the hardware write-protect input is held low. Software issues lock, unlock and pin commands against a block index. The write-protect input decides whether pinning is enforced. Reset puts every block into the locked state and clears every pin marker.

A command port updates the per-block state. A query port reports the state of any block combinationally. A program/erase request port returns a one-cycle accept or reject pulse, judged against the state in the cycle of the request. Each block holds a lock bit and a separate pin marker. The marker survives while write-protect is high, so the block can become pinned again when the input returns low. Only reset clears a marker.

Top module: `blk_protect_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, every block reports locked (`qry_state` = 2'b01) and no block reports pinned.
- R2: A command with `cmd_op` = 2'b00 (lock) makes the selected block report locked from the cycle after the command, at either write-protect level.
- R3: A command with `cmd_op` = 2'b01 (unlock) on a block with no pin marker makes it report open (`qry_state` = 2'b00) from the cycle after, at either write-protect level.
- R4: A command with `cmd_op` = 2'b10 (pin) sets both the lock bit and the pin marker. With the registered write-protect level low, the block then reports pinned (`qry_state` = 2'b10).
- R5: While the registered write-protect level is low, an unlock command to a block with a pin marker is ignored, and the block keeps reporting pinned.
- R6: While the registered write-protect level is high, a marked block reports locked, and software lock and unlock commands act on it as on any other block.
- R7: `wprot_n` is registered once. In the cycle a change of level is captured, every marked block has its lock bit set. This relock wins over an unlock to that block in the same cycle. An unlock in the same cycle as a rising change is judged against the old, low level.
- R8: No command clears a pin marker. After any sequence of commands with write-protect high, a marked block reports pinned again once write-protect is low.
- R9: A request on `pe_valid` gives, one cycle later, a single-cycle `pe_ok` pulse if the addressed block was open in the request cycle. Otherwise it gives a single-cycle `pe_err` pulse. Neither output pulses without a request.
- R10: Indices at or above NUM_BLOCKS are ignored by commands, query as locked, and have their program/erase requests rejected. Opcode 2'b11 changes no block.
- R11: `qry_wr_ok` is 1 exactly when the queried block reports open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; release leaves all blocks locked |
| wprot_n | input | 1 | Write-protect level; low enforces pinning |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 lock, 01 unlock, 10 pin, 11 reserved |
| cmd_blk | input | IDX_W | Block index for the command |
| pe_valid | input | 1 | Program/erase permission request |
| pe_blk | input | IDX_W | Block index for the request |
| qry_blk | input | IDX_W | Block index to report |
| qry_state | output | 2 | 00 open, 01 locked, 10 pinned |
| qry_wr_ok | output | 1 | Queried block may be programmed or erased |
| pe_ok | output | 1 | Request accepted (one-cycle pulse) |
| pe_err | output | 1 | Request rejected (one-cycle pulse) |

## Verification
The sharp overlap is a change of the write-protect level captured in the same cycle as a software unlock aimed at a marked block. The relock from the level change and the unlock both want the lock bit. The bench provokes this in both directions on purpose, and again during its sweep, where the level flips on chosen indices while commands run. It judges the outcome against a reference model in which the relock wins and the unlock is weighed against the old level. A second overlap, a program request in the same cycle as a command to the same block, is judged on the state before the command.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;

  typedef enum logic [1:0] {
    OP_LOCK   = 2'b00,
    OP_UNLOCK = 2'b01,
    OP_PIN    = 2'b10,
    OP_RSVD   = 2'b11
  } prot_op_e;

  typedef enum logic [1:0] {
    ST_OPEN   = 2'b00,
    ST_LOCKED = 2'b01,
    ST_PINNED = 2'b10
  } prot_st_e;

  // Reported state from the stored bits and the registered write-protect level.
  function automatic prot_st_e blk_state(input logic lock_b, input logic mark_b,
                                         input logic wp_lvl);
    if (mark_b && !wp_lvl) return ST_PINNED;
    if (lock_b)            return ST_LOCKED;
    return ST_OPEN;
  endfunction

  // Software unlock is honoured only when pinning is not enforced now and
  // no level change is being captured in the same cycle.
  function automatic logic unlock_allowed(input logic mark_b, input logic wp_lvl,
                                          input logic wp_move);
    return !(mark_b && (!wp_lvl || wp_move));
  endfunction

endpackage

// File: rtl/bp_wp_tracker.sv
module bp_wp_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic wprot_n,
  output logic wp_lvl,
  output logic wp_move
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_lvl <= 1'b0;
    else        wp_lvl <= wprot_n;
  end

  assign wp_move = (wprot_n != wp_lvl);

endmodule

// File: rtl/bp_block_cell.sv
module bp_block_cell
  import blkprot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sel,
  input  prot_op_e op,
  input  logic     wp_lvl,
  input  logic     wp_move,
  output logic     lock_q,
  output logic     mark_q
);

  logic lock_d, mark_d;
  logic relock_ev;
  logic unlock_ev;

  assign relock_ev = wp_move && mark_q;
  assign unlock_ev = sel && (op == OP_UNLOCK) && unlock_allowed(mark_q, wp_lvl, wp_move);

  always_comb begin
    lock_d = lock_q;
    mark_d = mark_q;
    if (relock_ev) lock_d = 1'b1;
    if (sel) begin
      unique case (op)
        OP_LOCK:   lock_d = 1'b1;
        OP_PIN: begin
          lock_d = 1'b1;
          mark_d = 1'b1;
        end
        OP_UNLOCK: if (unlock_ev) lock_d = 1'b0;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      mark_q <= 1'b0;
    end else begin
      lock_q <= lock_d;
      mark_q <= mark_d;
    end
  end

  // R5: a pinned block always carries its lock bit
  p_pinned_holds_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_q && !wp_lvl) |-> lock_q);

  // R5: an unlock while pinning is enforced leaves the block locked
  p_unlock_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_UNLOCK && mark_q && !wp_lvl) |=> lock_q);

  // R8: a marker, once set, stays until reset
  p_marker_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |=> mark_q);

  // R4: a pin command sets both bits
  p_pin_sets_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_PIN) |=> (lock_q && mark_q));

  // R7: a captured level change relocks a marked block
  p_relock_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_move && mark_q) |=> lock_q);

endmodule

// File: rtl/bp_access_port.sv
module bp_access_port
  import blkprot_pkg::*;
#(
  parameter int NUM_BLOCKS = 39,
  parameter int IDX_W      = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_BLOCKS-1:0] lock_vec,
  input  logic [NUM_BLOCKS-1:0] mark_vec,
  input  logic                  wp_lvl,
  input  logic [IDX_W-1:0]      qry_blk,
  input  logic                  pe_valid,
  input  logic [IDX_W-1:0]      pe_blk,
  output logic [1:0]            qry_state,
  output logic                  qry_wr_ok,
  output logic                  pe_ok,
  output logic                  pe_err
);

  localparam int SLOTS = 1 << IDX_W;

  // Unused index slots read as locked and unmarked.
  logic [SLOTS-1:0] lock_pad, mark_pad;

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_pad
      if (s < NUM_BLOCKS) begin : g_real
        assign lock_pad[s] = lock_vec[s];
        assign mark_pad[s] = mark_vec[s];
      end else begin : g_gap
        assign lock_pad[s] = 1'b1;
        assign mark_pad[s] = 1'b0;
      end
    end
  endgenerate

  prot_st_e q_st, pe_st;

  assign q_st      = blk_state(lock_pad[qry_blk], mark_pad[qry_blk], wp_lvl);
  assign pe_st     = blk_state(lock_pad[pe_blk],  mark_pad[pe_blk],  wp_lvl);
  assign qry_state = q_st;
  assign qry_wr_ok = (q_st == ST_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_ok  <= 1'b0;
      pe_err <= 1'b0;
    end else begin
      pe_ok  <= pe_valid && (pe_st == ST_OPEN);
      pe_err <= pe_valid && (pe_st != ST_OPEN);
    end
  end

  // R9: every request yields exactly one verdict
  p_pe_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pe_valid |=> ($countones({pe_ok, pe_err}) == 1));

  // R9: no verdict without a request
  p_pe_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_valid |=> !(pe_ok || pe_err));

  // R10: indices past the array read as locked
  p_gap_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(qry_blk) >= NUM_BLOCKS) |-> (qry_state == 2'b01));

endmodule

// File: rtl/blk_protect_ctrl.sv
module blk_protect_ctrl
  import blkprot_pkg::*;
#(
  parameter int  NUM_BLOCKS = 39,
  localparam int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wprot_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_blk,
  input  logic             pe_valid,
  input  logic [IDX_W-1:0] pe_blk,
  input  logic [IDX_W-1:0] qry_blk,
  output logic [1:0]       qry_state,
  output logic             qry_wr_ok,
  output logic             pe_ok,
  output logic             pe_err
);

  logic                  wp_lvl, wp_move;
  logic [NUM_BLOCKS-1:0] lock_vec, mark_vec, sel_vec;
  prot_op_e              op_e;

  assign op_e = prot_op_e'(cmd_op);

  bp_wp_tracker u_wp (
    .clk     (clk),
    .rst_n   (rst_n),
    .wprot_n (wprot_n),
    .wp_lvl  (wp_lvl),
    .wp_move (wp_move)
  );

  generate
    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
      assign sel_vec[i] = cmd_valid && (cmd_blk == IDX_W'(i));
      bp_block_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel_vec[i]),
        .op      (op_e),
        .wp_lvl  (wp_lvl),
        .wp_move (wp_move),
        .lock_q  (lock_vec[i]),
        .mark_q  (mark_vec[i])
      );
    end
  endgenerate

  bp_access_port #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .IDX_W      (IDX_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_vec  (lock_vec),
    .mark_vec  (mark_vec),
    .wp_lvl    (wp_lvl),
    .qry_blk   (qry_blk),
    .pe_valid  (pe_valid),
    .pe_blk    (pe_blk),
    .qry_state (qry_state),
    .qry_wr_ok (qry_wr_ok),
    .pe_ok     (pe_ok),
    .pe_err    (pe_err)
  );

  // R2: at most one block is selected per command
  p_single_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

endmodule

// File: tb/tb_blk_protect_ctrl.sv
module tb_blk_protect_ctrl;

  localparam int NB   = 5;
  localparam int IW   = 3;
  localparam int SLOT = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wprot_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [IW-1:0] cmd_blk = '0;
  logic          pe_valid = 1'b0;
  logic [IW-1:0] pe_blk = '0;
  logic [IW-1:0] qry_blk = '0;
  logic [1:0]    qry_state;
  logic          qry_wr_ok, pe_ok, pe_err;

  always #10 clk = ~clk;

  blk_protect_ctrl #(.NUM_BLOCKS(NB)) dut (
    .clk(clk), .rst_n(rst_n), .wprot_n(wprot_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .pe_valid(pe_valid), .pe_blk(pe_blk), .qry_blk(qry_blk),
    .qry_state(qry_state), .qry_wr_ok(qry_wr_ok), .pe_ok(pe_ok), .pe_err(pe_err)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  bit  m_lock [NB];
  bit  m_mark [NB];
  bit  m_wp;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int want_state(input int b);
    if (b >= NB) return 1;
    if (m_mark[b] && !m_wp) return 2;
    return m_lock[b] ? 1 : 0;
  endfunction

  function automatic void model_reset();
    for (int k = 0; k < NB; k++) begin
      m_lock[k] = 1;
      m_mark[k] = 0;
    end
    m_wp = 0;
  endfunction

  task automatic sweep_query(input string tag);
    for (int q = 0; q < SLOT; q++) begin
      qry_blk = IW'(q);
      #1;
      chk((q >= NB) ? "R10" : tag, $sformatf("state blk%0d", q), int'(qry_state), want_state(q));
      if (q == 0) chk("R11", "wr_ok blk0", int'(qry_wr_ok), (want_state(0) == 0) ? 1 : 0);
    end
  endtask

  // Called at a negedge; returns at the next negedge.
  task automatic step(input string tag, input bit v, input int op, input int b,
                      input bit wp, input bit pv, input int pb);
    bit exp_ok, exp_err, chg;
    exp_ok  = pv && (want_state(pb) == 0);
    exp_err = pv && !exp_ok;
    chg     = (wp != m_wp);
    for (int k = 0; k < NB; k++) if (chg && m_mark[k]) m_lock[k] = 1;
    if (v && b < NB) begin
      case (op)
        0: m_lock[b] = 1;
        2: begin m_lock[b] = 1; m_mark[b] = 1; end
        1: if (!(m_mark[b] && (!m_wp || chg))) m_lock[b] = 0;
        default: ;
      endcase
    end
    m_wp = wp;
    cmd_valid = v; cmd_op = op[1:0]; cmd_blk = IW'(b);
    wprot_n = wp; pe_valid = pv; pe_blk = IW'(pb);
    @(posedge clk);
    #1;
    cmd_valid = 0; pe_valid = 0;
    chk("R9", "pe_ok", int'(pe_ok), int'(exp_ok));
    chk("R9", "pe_err", int'(pe_err), int'(exp_err));
    sweep_query(tag);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    model_reset();
    #1;
    sweep_query("R1");
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL ALL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    do_reset();
    step("R1", 0, 0, 0, 0, 0, 0);
    // R4 pin with protect low, R5 unlock refused, R9 request rejected
    step("R4", 1, 2, 1, 0, 1, 1);
    step("R5", 1, 1, 1, 0, 1, 1);
    // R3 unlock unmarked block while protect low, R9 accepted next
    step("R3", 1, 1, 2, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 1, 2);
    // R6 protect high: marked block reads locked, can be opened
    step("R6", 0, 0, 0, 1, 0, 0);
    step("R6", 1, 1, 1, 1, 1, 1);
    step("R6", 0, 0, 0, 1, 1, 1);
    // R8 every opcode on marked block with protect high, then protect low
    step("R8", 1, 0, 1, 1, 0, 0);
    step("R8", 1, 1, 1, 1, 0, 0);
    step("R8", 1, 3, 1, 1, 0, 0);
    step("R8", 1, 1, 1, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0);
    // R7 collisions: unlock on falling capture, unlock on rising capture
    step("R7", 1, 2, 3, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 0);
    step("R7", 1, 1, 3, 1, 0, 0);
    step("R7", 1, 1, 3, 0, 0, 0);
    step("R7", 1, 1, 3, 1, 0, 0);
    step("R7", 1, 1, 3, 1, 0, 0);
    // R2 lock at both levels, R10 reserved op and gap indices
    step("R2", 1, 0, 2, 1, 1, 2);
    step("R10", 1, 3, 0, 1, 0, 0);
    step("R10", 1, 1, 6, 1, 1, 7);
    // Near-exhaustive sweep with level flips on chosen indices
    for (int rep = 0; rep < 2; rep++)
      for (int w = 0; w < 2; w++)
        for (int op = 0; op < 4; op++)
          for (int b = 0; b < SLOT; b++) begin
            bit wpi;
            string tg;
            wpi = (b == 2 || b == 5) ? !w[0] : w[0];
            if (wpi != m_wp)          tg = "R7";
            else if (op == 3 || b >= NB) tg = "R10";
            else if (op == 0)         tg = "R2";
            else if (op == 2)         tg = "R4";
            else if (b < NB && m_mark[b]) tg = m_wp ? "R6" : "R5";
            else                      tg = "R3";
            step(tg, 1, op, b, wpi, 1, (b * 3 + rep) % SLOT);
          end
    // R1 / R8 reset clears markers: protect low afterwards shows locked, not pinned
    do_reset();
    step("R1", 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 1, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule